// File: doc/BRIEF.md
# Instruction/Data Flash Read Controller with Line Prefetch

This block sits between two CPU-side read ports and a slow flash array that delivers 64 bits per access. One port carries instruction fetches and the other carries data loads. Each port returns a 32-bit word. A programmable count of wait states stretches every array access. Instruction fetches are served from a two-line buffer of 64-bit lines. While the core consumes one line word by word, the controller reads the following line into the buffer in the background, so sequential code rarely waits on the array. Data loads always go to the array, without touching the buffer, and they win whenever both ports ask at once.

The sequencer has four named states. IDLE arbitrates. DATA_RD performs a data load. DEMAND_RD performs an instruction read after a buffer miss. PREF_RD performs a background read of the next line. The transitions out of IDLE are tried in this order:
1. A pending data request enters DATA_RD.
2. An instruction miss, or any fetch while the prefetcher is switched off, flushes the buffer and enters DEMAND_RD.
3. An instruction hit whose successor line is not already buffered enters PREF_RD.

Each busy state returns to IDLE on the cycle its wait counter expires. Instruction hits are answered straight from the buffer in every state except DEMAND_RD. The addressable space is 128 pages of 2 KiB, so byte addresses are 18 bits wide.

Top module: `fetch_read_ctrl`

## Requirements
- R1: After reset no array access is in progress, both ready outputs are low, and the line buffer is empty, so the first fetch always reads the array.
- R2: Every array access holds `arr_addr` and drives `arr_strobe` for exactly `cfg_wait`+1 consecutive cycles. The count is taken when the access starts, so a changed value applies from the next access onward.
- R3: A data request returns the 32-bit word at `dat_addr`. The line address is address bits [17:3], and bit 2 set selects bits [63:32] of the line. The answer comes `cfg_wait`+1 cycles after the request is presented to an idle controller, and it never places a line in the buffer.
- R4: When both ports present requests to an idle controller in the same cycle, the data line is read first and the data response precedes the instruction response.
- R5: With `cfg_pf_off` low (its reset-inactive state, so prefetch is active out of reset), an instruction miss is answered after `cfg_wait`+1 cycles and its line is kept. A fetch of the other word of that line is answered in the cycle it is presented.
- R6: An instruction hit on a line whose successor (line address +1, wrapping) is not buffered starts a background read of that successor. Eight sequential word fetches from an aligned line L therefore cause array reads of L, L+1, L+2, L+3 and L+4, in that order, and the ninth word is answered without waiting.
- R7: An instruction miss invalidates both buffered lines.
- R8: A data read leaves both buffered lines intact, so fetches to them are still answered without waiting.
- R9: A change of `cfg_wait`, or a rise of `cfg_pf_off`, invalidates both buffered lines.
- R10: While `cfg_pf_off` is high, every instruction fetch reads the array, including repeated fetches to the same line.
- R11: With `cfg_half` high, `arr_strobe` is only driven during the high phase of the clock.
- R12: An instruction hit is answered in the same cycle in which a data read claims the array.
- R13: Fetches at the top of the address space are correct, and the successor of the last line is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wait | input | 3 | Wait states added to each array access |
| cfg_pf_off | input | 1 | High disables the line buffer and prefetching |
| cfg_half | input | 1 | High limits the array strobe to the high clock phase |
| ins_addr | input | 18 | Instruction fetch byte address |
| ins_valid | input | 1 | Instruction request, held until accepted |
| ins_ready | output | 1 | Instruction word delivered this cycle |
| ins_rdata | output | 32 | Instruction word |
| dat_addr | input | 18 | Data load byte address |
| dat_valid | input | 1 | Data request, held until accepted |
| dat_ready | output | 1 | Data word delivered this cycle |
| dat_rdata | output | 32 | Data word |
| arr_addr | output | 15 | Array line address |
| arr_strobe | output | 1 | Array access strobe |
| arr_rdata | input | 64 | Line returned by the array |

## Verification
The overlap of interest is an instruction hit served from the buffer in the same cycle that a data load takes the array. The bench provokes it by buffering a line and then presenting both a data request and a fetch of that line on the same idle edge. It judges the result by requiring a zero-wait instruction answer together with a data answer after the full wait count. A second collision, an instruction miss arriving together with a data load, is judged against a queue of array line addresses that the bench logs at every strobe start. That queue must show the data line ahead of the instruction line, and the data handshake must occur on an earlier cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int WORD_W = 32;
    localparam int LINE_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_DEMAND = 2'd2,
        ST_PREF   = 2'd3
    } fetch_state_e;

    // Pick one 32-bit half of a 64-bit line; upper selects bits [63:32].
    function automatic logic [WORD_W-1:0] word_of_line(input logic [LINE_W-1:0] line,
                                                       input logic upper);
        return upper ? line[LINE_W-1:WORD_W] : line[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/fetch_wait_timer.sv
module fetch_wait_timer #(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] load,
    input  logic            busy,
    output logic            done
);

    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (busy && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);

    // R2: an access may only be launched from the idle state
    p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R2: the sequencer leaves its busy state right after expiry
    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/fetch_line_buf.sv
module fetch_line_buf #(
    parameter int TAG_W  = 15,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              wr_slot,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              hit,
    output logic              hit_slot,
    output logic [LINE_W-1:0] hit_data,
    output logic              next_held
);

    localparam int SLOTS = 2;
    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

    logic              vld   [SLOTS];
    logic [TAG_W-1:0]  tag_q [SLOTS];
    logic [LINE_W-1:0] dat_q [SLOTS];
    logic [SLOTS-1:0]  match;
    logic              other;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[s]   <= 1'b0;
                tag_q[s] <= '0;
                dat_q[s] <= '0;
            end else if (flush) begin
                vld[s]   <= 1'b0;
            end else if (wr_en && wr_slot == 1'(s)) begin
                vld[s]   <= 1'b1;
                tag_q[s] <= wr_tag;
                dat_q[s] <= wr_data;
            end
        end
        assign match[s] = vld[s] && (tag_q[s] == lk_tag);
    end

    assign hit       = |match;
    assign hit_slot  = match[1];
    assign hit_data  = dat_q[hit_slot];
    assign other     = !hit_slot;
    assign next_held = vld[other] && (tag_q[other] == lk_tag + TAG_ONE);

    // R9: a flush leaves no line valid
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!vld[0] && !vld[1]));

    // R6: a line address is never held in both slots
    p_unique_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R5: a write into slot 0 without a flush makes that slot valid
    p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && !wr_slot) |=> vld[0]);

endmodule

// File: rtl/fetch_read_ctrl.sv
module fetch_read_ctrl
    import fetch_pkg::*;
#(
    parameter int PAGES      = 128,
    parameter int PAGE_BYTES = 2048,
    parameter int WS_W       = 3,
    localparam int AW        = $clog2(PAGES * PAGE_BYTES),
    localparam int TAG_W     = AW - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WS_W-1:0]   cfg_wait,
    input  logic              cfg_pf_off,
    input  logic              cfg_half,
    input  logic [AW-1:0]     ins_addr,
    input  logic              ins_valid,
    output logic              ins_ready,
    output logic [WORD_W-1:0] ins_rdata,
    input  logic [AW-1:0]     dat_addr,
    input  logic              dat_valid,
    output logic              dat_ready,
    output logic [WORD_W-1:0] dat_rdata,
    output logic [TAG_W-1:0]  arr_addr,
    output logic              arr_strobe,
    input  logic [LINE_W-1:0] arr_rdata
);

    localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

    fetch_state_e      st_q, st_d;
    logic [TAG_W-1:0]  line_q, line_d;
    logic              pf_slot_q, pf_slot_d;
    logic              kill_q;
    logic [WS_W-1:0]   wait_q;
    logic              pf_off_q;

    logic              start, demand_flush, flush_cfg, flush_buf;
    logic              busy, done;
    logic              hit, hit_slot, next_held, hit_ok;
    logic [LINE_W-1:0] hit_data;
    logic              buf_we, buf_slot;
    logic [TAG_W-1:0]  ins_tag, dat_tag;
    logic              unused_bits;

    assign ins_tag     = ins_addr[AW-1:3];
    assign dat_tag     = dat_addr[AW-1:3];
    assign unused_bits = ^{ins_addr[1:0], dat_addr[1:0]};
    assign busy        = (st_q != ST_IDLE);
    assign flush_cfg   = (cfg_wait != wait_q) || (cfg_pf_off && !pf_off_q);
    assign flush_buf   = flush_cfg || demand_flush;
    assign hit_ok      = ins_valid && hit && !cfg_pf_off;

    fetch_line_buf #(
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_buf),
        .wr_en     (buf_we),
        .wr_slot   (buf_slot),
        .wr_tag    (line_q),
        .wr_data   (arr_rdata),
        .lk_tag    (ins_tag),
        .hit       (hit),
        .hit_slot  (hit_slot),
        .hit_data  (hit_data),
        .next_held (next_held)
    );

    fetch_wait_timer #(
        .WS_W (WS_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (cfg_wait),
        .busy  (busy),
        .done  (done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Access context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= '0;
            pf_slot_q <= 1'b0;
            kill_q    <= 1'b0;
            wait_q    <= '0;
            pf_off_q  <= 1'b0;
        end else begin
            line_q    <= line_d;
            pf_slot_q <= pf_slot_d;
            wait_q    <= cfg_wait;
            pf_off_q  <= cfg_pf_off;
            if (start) begin
                kill_q <= 1'b0;
            end else if (st_q == ST_PREF && flush_cfg) begin
                kill_q <= 1'b1;
            end
        end
    end

    // Next state: data first, then demand on miss, then background line
    always_comb begin
        st_d         = st_q;
        line_d       = line_q;
        pf_slot_d    = pf_slot_q;
        start        = 1'b0;
        demand_flush = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (dat_valid) begin
                    st_d   = ST_DATA;
                    line_d = dat_tag;
                    start  = 1'b1;
                end else if (ins_valid && !hit_ok) begin
                    st_d         = ST_DEMAND;
                    line_d       = ins_tag;
                    start        = 1'b1;
                    demand_flush = 1'b1;
                end else if (hit_ok && !next_held) begin
                    st_d      = ST_PREF;
                    line_d    = ins_tag + TAG_ONE;
                    pf_slot_d = !hit_slot;
                    start     = 1'b1;
                end
            end
            ST_DATA, ST_DEMAND, ST_PREF: begin
                if (done) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs and buffer fills
    always_comb begin
        ins_ready = 1'b0;
        ins_rdata = '0;
        dat_ready = 1'b0;
        dat_rdata = '0;
        buf_we    = 1'b0;
        buf_slot  = 1'b0;
        unique case (st_q)
            ST_DATA: begin
                if (done) begin
                    dat_ready = 1'b1;
                    dat_rdata = word_of_line(arr_rdata, dat_addr[2]);
                end
            end
            ST_DEMAND: begin
                if (done) begin
                    ins_ready = 1'b1;
                    ins_rdata = word_of_line(arr_rdata, ins_addr[2]);
                    buf_we    = !cfg_pf_off;
                    buf_slot  = 1'b0;
                end
            end
            ST_PREF: begin
                if (done) begin
                    buf_we   = !kill_q && !cfg_pf_off;
                    buf_slot = pf_slot_q;
                end
            end
            default: ;
        endcase
        if (hit_ok && st_q != ST_DEMAND) begin
            ins_ready = 1'b1;
            ins_rdata = word_of_line(hit_data, ins_addr[2]);
        end
    end

    assign arr_addr   = line_q;
    assign arr_strobe = busy && (!cfg_half || clk);

    // R4: simultaneous requests from idle go to the data line first
    p_data_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && dat_valid && ins_valid)
            |=> (st_q == ST_DATA && arr_addr == $past(dat_tag)));

    // R2: the line address does not move during an access
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr));

    // R3: a data answer is a single-cycle pulse
    p_dat_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |=> !dat_ready);

    // R10: with prefetch off, instruction words come only from the array
    p_off_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pf_off && ins_ready) |-> (st_q == ST_DEMAND));

    // R6: a hit that launches a background read targets the successor line
    p_pref_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && hit_ok && !dat_valid && !next_held)
            |=> (arr_addr == $past(ins_tag) + TAG_ONE));

endmodule

// File: tb/fetch_read_ctrl_bench.sv
`timescale 1ns/1ps
module fetch_read_ctrl_bench;

    localparam int AW   = 18;
    localparam int TW   = 15;
    localparam int WS_W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [WS_W-1:0] cfg_wait;
    logic            cfg_pf_off, cfg_half;
    logic [AW-1:0]   ins_addr, dat_addr;
    logic            ins_valid, dat_valid, ins_ready, dat_ready;
    logic [31:0]     ins_rdata, dat_rdata;
    logic [TW-1:0]   arr_addr;
    logic            arr_strobe;
    logic [63:0]     arr_rdata;

    always #10 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [AW-3:0] w);
        return (32'(w) * 32'h9E37_79B1) ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [AW-1:0] line_byte(input int line, input int word);
        return {TW'(line), word[0], 2'b00};
    endfunction

    // Behavioural array: the full line for the presented address
    assign arr_rdata = {mem_word({arr_addr, 1'b1}), mem_word({arr_addr, 1'b0})};

    fetch_read_ctrl u_fetch_read_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wait   (cfg_wait),
        .cfg_pf_off (cfg_pf_off),
        .cfg_half   (cfg_half),
        .ins_addr   (ins_addr),
        .ins_valid  (ins_valid),
        .ins_ready  (ins_ready),
        .ins_rdata  (ins_rdata),
        .dat_addr   (dat_addr),
        .dat_valid  (dat_valid),
        .dat_ready  (dat_ready),
        .dat_rdata  (dat_rdata),
        .arr_addr   (arr_addr),
        .arr_strobe (arr_strobe),
        .arr_rdata  (arr_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) cyc++;

    // Array access log, sampled in the high clock phase
    logic [TW-1:0] acc_q[$];
    bit in_run = 0;
    int run_len = 0, run_wait = 0, last_len = 0, half_runs = 0, half_bad = 0;

    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (arr_strobe) begin
                if (!in_run) begin
                    in_run   = 1;
                    run_len  = 0;
                    run_wait = int'(cfg_wait);
                    acc_q.push_back(arr_addr);
                    if (cfg_half) half_runs++;
                end
                run_len++;
            end else if (in_run) begin
                in_run   = 0;
                last_len = run_len;
                chk(run_len == run_wait + 1, "R2", "strobe length", run_len, run_wait + 1);
            end
        end
    end

    // Handshakes and low-phase strobe, sampled just before the next edge
    int ins_xfer_cyc = 0, dat_xfer_cyc = 0;
    always @(negedge clk) begin
        #5;
        if (rst_n) begin
            if (ins_valid && ins_ready) begin
                chk(ins_rdata == mem_word(ins_addr[AW-1:2]), "R5", "instruction word",
                    ins_rdata, mem_word(ins_addr[AW-1:2]));
                ins_xfer_cyc = cyc;
            end
            if (dat_valid && dat_ready) begin
                chk(dat_rdata == mem_word(dat_addr[AW-1:2]), "R3", "data word",
                    dat_rdata, mem_word(dat_addr[AW-1:2]));
                dat_xfer_cyc = cyc;
            end
            if (cfg_half && arr_strobe) half_bad++;
        end
    end

    task automatic fetch(input logic [AW-1:0] a, output int waited);
        @(negedge clk);
        ins_addr  = a;
        ins_valid = 1'b1;
        waited    = 0;
        #5;
        while (!ins_ready) begin
            @(negedge clk);
            #5;
            waited++;
        end
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic dread(input logic [AW-1:0] a, output int waited);
        @(negedge clk);
        dat_addr  = a;
        dat_valid = 1'b1;
        waited    = 0;
        #5;
        while (!dat_ready) begin
            @(negedge clk);
            #5;
            waited++;
        end
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int w, iw, dw, k;
        cfg_wait = 3'd2; cfg_pf_off = 1'b0; cfg_half = 1'b0;
        ins_addr = '0; dat_addr = '0; ins_valid = 1'b0; dat_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!arr_strobe && !ins_ready && !dat_ready, "R1", "outputs in reset",
            {arr_strobe, ins_ready, dat_ready}, 0);
        rst_n = 1'b1;
        idle(3);
        chk(!arr_strobe && acc_q.size() == 0, "R1", "quiet after reset", acc_q.size(), 0);

        // R1/R5: first fetch misses, its neighbour word hits
        fetch(line_byte(10, 0), w);
        chk(w == 3, "R1", "first fetch wait", w, 3);
        fetch(line_byte(10, 1), w);
        chk(w == 0, "R5", "same-line word wait", w, 0);
        idle(10);

        // R6: sequential stream
        k = acc_q.size();
        for (int i = 0; i < 8; i++) begin
            fetch(line_byte(40 + i / 2, i % 2), w);
        end
        idle(12);
        chk(acc_q.size() - k == 5, "R6", "array reads for 8 words", acc_q.size() - k, 5);
        for (int j = 0; j < 5; j++) begin
            chk(acc_q[k + j] == TW'(40 + j), "R6", "read order", acc_q[k + j], 40 + j);
        end
        fetch(line_byte(44, 0), w);
        chk(w == 0, "R6", "ninth word wait", w, 0);
        idle(10);

        // R8/R3: data read leaves lines intact and fills nothing
        fetch(line_byte(70, 0), w);
        fetch(line_byte(70, 1), w);
        idle(10);
        dread(line_byte(200, 1), w);
        chk(w == 3, "R3", "data wait", w, 3);
        fetch(line_byte(70, 0), w);
        chk(w == 0, "R8", "line kept over data read", w, 0);
        fetch(line_byte(71, 0), w);
        chk(w == 0, "R8", "background line kept", w, 0);
        idle(10);
        fetch(line_byte(200, 0), w);
        chk(w == 3, "R3", "data line not buffered", w, 3);

        // R12: hit served while data read takes the array
        fetch(line_byte(200, 1), w);
        idle(10);
        fork
            dread(line_byte(300, 0), dw);
            fetch(line_byte(200, 0), iw);
        join
        chk(iw == 0, "R12", "hit wait during data read", iw, 0);
        chk(dw == 3, "R12", "data wait beside hit", dw, 3);
        idle(2);

        // R4: data wins against an instruction miss
        k = acc_q.size();
        fork
            dread(line_byte(310, 1), dw);
            fetch(line_byte(400, 0), iw);
        join
        idle(10);
        chk(acc_q[k] == TW'(310), "R4", "first line read", acc_q[k], 310);
        chk(acc_q[k + 1] == TW'(400), "R4", "second line read", acc_q[k + 1], 400);
        chk(dat_xfer_cyc < ins_xfer_cyc, "R4", "answer order", dat_xfer_cyc, ins_xfer_cyc);

        // R7: the miss dropped line 200
        fetch(line_byte(200, 0), w);
        chk(w == 3, "R7", "line refetched after miss", w, 3);

        // R9: wait change invalidates, new count applies
        fetch(line_byte(200, 1), w);
        idle(10);
        cfg_wait = 3'd1;
        idle(2);
        fetch(line_byte(200, 0), w);
        chk(w == 2, "R9", "refetch after wait change", w, 2);

        // R10: prefetch off reads every time
        fetch(line_byte(200, 1), w);
        idle(10);
        cfg_pf_off = 1'b1;
        idle(2);
        fetch(line_byte(200, 1), w);
        chk(w == 2, "R10", "off fetch 1", w, 2);
        fetch(line_byte(200, 1), w);
        chk(w == 2, "R10", "off fetch 2", w, 2);
        cfg_pf_off = 1'b0;
        idle(2);
        fetch(line_byte(200, 0), w);
        chk(w == 2, "R9", "miss after re-enable", w, 2);
        idle(10);

        // R2: extreme wait counts
        cfg_wait = 3'd0;
        idle(2);
        dread(line_byte(500, 0), w);
        idle(2);
        chk(w == 1 && last_len == 1, "R2", "zero-wait access", last_len, 1);
        cfg_wait = 3'd7;
        idle(2);
        dread(line_byte(501, 1), w);
        idle(2);
        chk(w == 8 && last_len == 8, "R2", "max-wait access", last_len, 8);

        // R11: half-phase strobe
        cfg_wait = 3'd3;
        cfg_half = 1'b1;
        idle(2);
        k = half_runs;
        dread(line_byte(600, 0), w);
        idle(3);
        chk(half_runs == k + 1, "R11", "strobe seen in high phase", half_runs, k + 1);
        chk(half_bad == 0, "R11", "strobe in low phase", half_bad, 0);
        cfg_half = 1'b0;
        idle(2);

        // R13: top of space and wrap of the successor line
        dread(18'h3FFFC, w);
        fetch(18'h3FFF8, w);
        fetch(18'h3FFFC, w);
        chk(w == 0, "R13", "top line hit", w, 0);
        idle(10);
        chk(acc_q[acc_q.size() - 1] == '0, "R13", "successor wraps",
            acc_q[acc_q.size() - 1], 0);

        done_flag = 1;
        summary();
        $finish;
    end

endmodule